// File: doc/BRIEF.md
# Load Result Aligner and Extender

This block sits at the end of the load path of a 64-bit core. Each request carries a 32-bit load instruction, the value of its base register and the aligned doubleword that memory returns for the request. The block decodes the instruction and forms the effective address. It drives the physical address to memory, including the byte-swap adjustment for reverse-endian mode. It then picks the addressed bytes out of the doubleword, extends them to 64 bits and presents a registered write to the destination register one cycle later.

Accesses that are not naturally aligned raise a one-cycle fault pulse, and no register write happens for them. A load-linked access that completes sets a sticky link flag. The flag is cleared by reset or by an external clear strobe. Upper-immediate instructions are handled on the same path, so one write port serves every instruction the block decodes.

Top module: `ld_align_unit`

## Requirements
- R1: `mem_addr` equals `base_val` plus the sign-extended low 16 instruction bits, combinationally, when `reverse_endian` is 0.
- R2: When `reverse_endian` is 1, the low three bits of `mem_addr` are XORed with 6 for halfword accesses and with 4 for word accesses. Doubleword accesses are left unchanged.
- R3: The byte lane is the effective address bits [2:0] XORed with an adjustment: 6 for a halfword, 4 for a word, 0 for a doubleword, applied only when `big_endian` is 1. The loaded value is `mem_rdata` shifted right by 8 times the lane.
- R4: A signed halfword load (opcode 100001) sign-extends 16 bits to 64. An unsigned halfword load (opcode 100101) zero-extends.
- R5: A word load (opcode 100011) and a load-linked word (opcode 110000) sign-extend 32 bits to 64. An unsigned word load (opcode 100111) zero-extends.
- R6: A load-linked doubleword (opcode 110100) writes all 64 bits unchanged.
- R7: An upper-immediate load (opcode 001111, bits [25:21] zero) writes the immediate into bits 31:16, with zeros in bits 15:0 and bit 31 copied into bits 63:32. With nonzero bits [25:21] it is not recognised and writes nothing.
- R8: A halfword access at an odd address, a word access with address bits [1:0] not zero, or a doubleword access with bits [2:0] not zero gives `fault`=1 and `wb_en`=0 in the following cycle, and leaves `link_flag` unchanged.
- R9: `wb_en`, `wb_idx` (instruction bits [20:16]), `wb_data` and `fault` reflect a request in the cycle after `req_valid`. An unrecognised opcode, or no request, gives `wb_en`=0 and `fault`=0.
- R10: A load-linked word or doubleword that does not fault sets `link_flag` in the same cycle as its write.
- R11: `link_clr` clears `link_flag` on the next edge and takes priority over a simultaneous set.
- R12: After reset, `wb_en`, `fault` and `link_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load instruction is presented this cycle |
| instr | input | 32 | Instruction word: opcode [31:26], base field [25:21], target [20:16], offset [15:0] |
| base_val | input | 64 | Value of the base register |
| big_endian | input | 1 | Big-endian byte ordering |
| reverse_endian | input | 1 | Reverse-endian mode, adjusts the physical address |
| link_clr | input | 1 | Clears the link flag |
| mem_addr | output | 64 | Physical address sent to memory |
| mem_rdata | input | 64 | Aligned doubleword returned for `mem_addr` |
| wb_en | output | 1 | Register write strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Aligned and extended result |
| fault | output | 1 | Misalignment fault pulse |
| link_flag | output | 1 | Sticky link bit |

## Verification
The assertions assume that `req_valid` and `link_clr` are driven to known values from reset onward. They also assume that `mem_rdata` is the doubleword for the current `mem_addr` in the same cycle. The bench drives every input at the falling edge and returns a constant doubleword, so memory is always consistent with any address. It holds `req_valid` to a single cycle per request, so each result can be tied to exactly one instruction.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_LDH   = 6'b100001;
   localparam logic [OPC_W-1:0] OPC_LDHU  = 6'b100101;
   localparam logic [OPC_W-1:0] OPC_LDW   = 6'b100011;
   localparam logic [OPC_W-1:0] OPC_LDWU  = 6'b100111;
   localparam logic [OPC_W-1:0] OPC_LNKW  = 6'b110000;
   localparam logic [OPC_W-1:0] OPC_LNKD  = 6'b110100;
   localparam logic [OPC_W-1:0] OPC_UPIMM = 6'b001111;

   // access size as log2 of the byte count
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } ld_size_e;

   typedef struct packed {
      logic     known;    // opcode recognised
      logic     imm_hi;   // upper-immediate, no memory access
      logic     sext;     // sign-extend the loaded field
      logic     linked;   // sets the link flag on success
      ld_size_e size;
   } ld_ctl_t;

endpackage

// File: rtl/ldx_decode.sv
module ldx_decode
   import ldx_pkg::*;
#(
   parameter int RA_W = 5
) (
   input  logic [OPC_W-1:0] opc,
   input  logic [RA_W-1:0]  rs_fld,
   output ld_ctl_t          ctl
);

   always_comb begin
      ctl = '{known: 1'b0, imm_hi: 1'b0, sext: 1'b0, linked: 1'b0, size: SZ_BYTE};
      unique case (opc)
         OPC_LDH:  begin ctl.known = 1'b1; ctl.sext = 1'b1; ctl.size = SZ_HALF;  end
         OPC_LDHU: begin ctl.known = 1'b1;                  ctl.size = SZ_HALF;  end
         OPC_LDW:  begin ctl.known = 1'b1; ctl.sext = 1'b1; ctl.size = SZ_WORD;  end
         OPC_LDWU: begin ctl.known = 1'b1;                  ctl.size = SZ_WORD;  end
         OPC_LNKW: begin
            ctl.known  = 1'b1;
            ctl.sext   = 1'b1;
            ctl.linked = 1'b1;
            ctl.size   = SZ_WORD;
         end
         OPC_LNKD: begin
            ctl.known  = 1'b1;
            ctl.linked = 1'b1;
            ctl.size   = SZ_DWORD;
         end
         OPC_UPIMM: begin
            // the base field must be zero for a legal encoding
            ctl.known  = (rs_fld == '0);
            ctl.imm_hi = (rs_fld == '0);
            ctl.size   = SZ_WORD;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/ldx_agen.sv
module ldx_agen
   import ldx_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int OFF_W = 16
) (
   input  logic [XLEN-1:0]             base,
   input  logic [OFF_W-1:0]            off,
   input  ld_size_e                    size,
   input  logic                        big,
   input  logic                        rev,
   output logic [XLEN-1:0]             paddr,
   output logic [$clog2(XLEN/8)-1:0]   lane,
   output logic                        misalign
);

   localparam int LANES = XLEN / 8;
   localparam int LGB   = $clog2(LANES);

   logic [XLEN-1:0] ea;
   logic [LGB-1:0]  acc_mask;
   logic [LGB-1:0]  flip;

   always_comb begin
      ea       = base + {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
      acc_mask = LGB'((32'd1 << size) - 32'd1);
      // bytes of the line above the access size are reordered in either mode
      flip     = {LGB{1'b1}} ^ acc_mask;
      misalign = |(ea[LGB-1:0] & acc_mask);
      lane     = ea[LGB-1:0] ^ (big ? flip : '0);
      paddr    = {ea[XLEN-1:LGB], ea[LGB-1:0] ^ (rev ? flip : '0)};
   end

endmodule

// File: rtl/ldx_lane.sv
module ldx_lane
   import ldx_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]           dw,
   input  logic [$clog2(XLEN/8)-1:0] lane,
   input  ld_size_e                  size,
   input  logic                      sext,
   output logic [XLEN-1:0]           val
);

   localparam int LGB   = $clog2(XLEN / 8);
   localparam int N_SZ  = 4;

   logic [XLEN-1:0] shifted;
   logic [XLEN-1:0] by_size [N_SZ];

   assign shifted = dw >> {lane, 3'b000};

   for (genvar g = 0; g < N_SZ; g++) begin : g_ext
      localparam int W = 8 << g;
      if (W == XLEN) begin : g_full
         assign by_size[g] = shifted;
      end else begin : g_part
         assign by_size[g] = {{(XLEN-W){sext & shifted[W-1]}}, shifted[W-1:0]};
      end
   end

   assign val = by_size[size];

   if (LGB < 3) begin : g_bad_lgb
      $error("ldx_lane: line must hold at least a doubleword");
   end

endmodule

// File: rtl/ld_align_unit.sv
module ld_align_unit
   import ldx_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int ILEN  = 32,
   parameter int RA_W  = 5,
   parameter int OFF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [ILEN-1:0]  instr,
   input  logic [XLEN-1:0]  base_val,
   input  logic             big_endian,
   input  logic             reverse_endian,
   input  logic             link_clr,
   output logic [XLEN-1:0]  mem_addr,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic             wb_en,
   output logic [RA_W-1:0]  wb_idx,
   output logic [XLEN-1:0]  wb_data,
   output logic             fault,
   output logic             link_flag
);

   localparam int LGB    = $clog2(XLEN / 8);
   localparam int RT_LSB = OFF_W;
   localparam int RS_LSB = OFF_W + RA_W;
   localparam int OP_LSB = OFF_W + 2 * RA_W;

   // elaboration checks on the parameter set
   if (ILEN != OPC_W + 2 * RA_W + OFF_W) begin : g_bad_ilen
      $error("ld_align_unit: instruction fields do not fill ILEN");
   end
   if (XLEN < 64 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("ld_align_unit: XLEN must be a power of two of at least 64");
   end
   if (OFF_W != 16) begin : g_bad_off
      $error("ld_align_unit: upper-immediate form needs a 16-bit field");
   end

   logic [OPC_W-1:0] f_op;
   logic [RA_W-1:0]  f_rs;
   logic [RA_W-1:0]  f_rt;
   logic [OFF_W-1:0] f_imm;

   assign f_op  = instr[OP_LSB +: OPC_W];
   assign f_rs  = instr[RS_LSB +: RA_W];
   assign f_rt  = instr[RT_LSB +: RA_W];
   assign f_imm = instr[OFF_W-1:0];

   ld_ctl_t         ctl;
   logic [LGB-1:0]  lane;
   logic            misalign;
   logic [XLEN-1:0] lane_val;
   logic [XLEN-1:0] upimm_val;
   logic [XLEN-1:0] result;
   logic            fault_now;
   logic            write_now;

   ldx_decode #(.RA_W(RA_W)) u_dec (
      .opc    (f_op),
      .rs_fld (f_rs),
      .ctl    (ctl)
   );

   ldx_agen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agen (
      .base     (base_val),
      .off      (f_imm),
      .size     (ctl.size),
      .big      (big_endian),
      .rev      (reverse_endian),
      .paddr    (mem_addr),
      .lane     (lane),
      .misalign (misalign)
   );

   ldx_lane #(.XLEN(XLEN)) u_lane (
      .dw   (mem_rdata),
      .lane (lane),
      .size (ctl.size),
      .sext (ctl.sext),
      .val  (lane_val)
   );

   assign upimm_val = {{(XLEN-32){f_imm[OFF_W-1]}}, f_imm, 16'h0000};
   assign result    = ctl.imm_hi ? upimm_val : lane_val;
   assign fault_now = req_valid & ctl.known & ~ctl.imm_hi & misalign;
   assign write_now = req_valid & ctl.known & ~fault_now;

   logic            wb_en_q;
   logic            fault_q;
   logic            link_q;
   logic [RA_W-1:0] idx_q;
   logic [XLEN-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_en_q <= 1'b0;
         fault_q <= 1'b0;
         link_q  <= 1'b0;
         idx_q   <= '0;
         data_q  <= '0;
      end else begin
         wb_en_q <= write_now;
         fault_q <= fault_now;
         if (write_now) begin
            idx_q  <= f_rt;
            data_q <= result;
         end
         if (link_clr)
            link_q <= 1'b0;
         else if (write_now && ctl.linked)
            link_q <= 1'b1;
      end
   end

   assign wb_en     = wb_en_q;
   assign fault     = fault_q;
   assign link_flag = link_q;
   assign wb_idx    = idx_q;
   assign wb_data   = data_q;

   a_r8_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !wb_en);

   a_r9_write_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(req_valid));

   a_r9_fault_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(req_valid));

   a_r10_link_rises_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_flag) |-> wb_en);

   a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      link_clr |=> !link_flag);

   a_r8_fault_keeps_link: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !$past(link_clr)) |-> $stable(link_flag));

endmodule

// File: tb/sim_ld_align_unit.sv
`timescale 1ns/1ps
module sim_ld_align_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] base_val = '0;
   logic        big_endian = 1'b0;
   logic        reverse_endian = 1'b0;
   logic        link_clr = 1'b0;
   logic [63:0] mem_addr;
   logic [63:0] mem_rdata;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [63:0] wb_data;
   logic        fault;
   logic        link_flag;

   // constant doubleword: bytes 7..0 = 71 62 D3 C4 B5 A6 97 88
   localparam logic [63:0] DW = 64'h7162_D3C4_B5A6_9788;
   assign mem_rdata = DW;

   always #2.5 clk = ~clk;

   ld_align_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
      .base_val(base_val), .big_endian(big_endian), .reverse_endian(reverse_endian),
      .link_clr(link_clr), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .fault(fault),
      .link_flag(link_flag)
   );

   int n_chk  = 0;
   int n_fail = 0;
   logic [63:0] seen_addr;

   localparam logic [5:0] LH = 6'b100001, LHU = 6'b100101, LW = 6'b100011,
                          LWU = 6'b100111, LL = 6'b110000, LLD = 6'b110100,
                          LUI = 6'b001111, NOP = 6'b000000;

   typedef struct packed {
      logic [5:0]  op;
      logic [4:0]  rt;
      logic [15:0] imm;
      logic [63:0] base;
      logic        be;
      logic [63:0] exp;
      logic        wb;
      logic        flt;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VT [NV] = '{
      '{LH,  5'd1,  16'h0006, 64'h100, 1'b0, 64'h0000_0000_0000_7162, 1'b1, 1'b0}, // R4
      '{LH,  5'd2,  16'h0000, 64'h100, 1'b0, 64'hFFFF_FFFF_FFFF_9788, 1'b1, 1'b0}, // R4
      '{LHU, 5'd3,  16'h0000, 64'h100, 1'b0, 64'h0000_0000_0000_9788, 1'b1, 1'b0}, // R4
      '{LH,  5'd4,  16'h0002, 64'h100, 1'b1, 64'hFFFF_FFFF_FFFF_D3C4, 1'b1, 1'b0}, // R3
      '{LW,  5'd5,  16'h0000, 64'h100, 1'b0, 64'hFFFF_FFFF_B5A6_9788, 1'b1, 1'b0}, // R5
      '{LWU, 5'd6,  16'h0000, 64'h100, 1'b0, 64'h0000_0000_B5A6_9788, 1'b1, 1'b0}, // R5
      '{LW,  5'd7,  16'h0000, 64'h100, 1'b1, 64'h0000_0000_7162_D3C4, 1'b1, 1'b0}, // R3
      '{LW,  5'd8,  16'h0004, 64'h100, 1'b1, 64'hFFFF_FFFF_B5A6_9788, 1'b1, 1'b0}, // R3
      '{LL,  5'd9,  16'hFFF8, 64'h110, 1'b0, 64'hFFFF_FFFF_B5A6_9788, 1'b1, 1'b0}, // R5 R1
      '{LLD, 5'd10, 16'h0000, 64'h100, 1'b0, 64'h7162_D3C4_B5A6_9788, 1'b1, 1'b0}, // R6
      '{LLD, 5'd11, 16'h0000, 64'h100, 1'b1, 64'h7162_D3C4_B5A6_9788, 1'b1, 1'b0}, // R6
      '{LUI, 5'd12, 16'h8001, 64'h100, 1'b0, 64'hFFFF_FFFF_8001_0000, 1'b1, 1'b0}, // R7
      '{LUI, 5'd13, 16'h1234, 64'h100, 1'b0, 64'h0000_0000_1234_0000, 1'b1, 1'b0}, // R7
      '{LL,  5'd14, 16'h0002, 64'h100, 1'b0, 64'h0,                   1'b0, 1'b1}, // R8
      '{LLD, 5'd15, 16'h0004, 64'h100, 1'b0, 64'h0,                   1'b0, 1'b1}, // R8
      '{LH,  5'd16, 16'h0001, 64'h100, 1'b0, 64'h0,                   1'b0, 1'b1}, // R8
      '{LW,  5'd17, 16'h0006, 64'h100, 1'b0, 64'h0,                   1'b0, 1'b1}, // R8
      '{NOP, 5'd18, 16'h0000, 64'h100, 1'b0, 64'h0,                   1'b0, 1'b0}, // R9
      '{LHU, 5'd19, 16'h0006, 64'h100, 1'b1, 64'h0000_0000_0000_9788, 1'b1, 1'b0}  // R3
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the result edge
   task automatic issue(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                        input logic [15:0] imm, input logic [63:0] base,
                        input logic be, input logic rev, input logic clr);
      instr          = {op, rs, rt, imm};
      base_val       = base;
      big_endian     = be;
      reverse_endian = rev;
      link_clr       = clr;
      req_valid      = 1'b1;
      #1 seen_addr   = mem_addr;
      @(negedge clk);
      req_valid = 1'b0;
      link_clr  = 1'b0;
   endtask

   task automatic finish_run;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 wb_en after reset", {63'd0, wb_en}, 64'd0);
      chk("R12 fault after reset", {63'd0, fault}, 64'd0);
      chk("R12 link_flag after reset", {63'd0, link_flag}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         issue(VT[i].op, 5'd0, VT[i].rt, VT[i].imm, VT[i].base, VT[i].be, 1'b0, 1'b0);
         if (VT[i].op != LUI && VT[i].op != NOP)
            chk($sformatf("R1 table[%0d] address", i), seen_addr,
                VT[i].base + {{48{VT[i].imm[15]}}, VT[i].imm});
         chk($sformatf("R9 table[%0d] wb_en", i), {63'd0, wb_en}, {63'd0, VT[i].wb});
         chk($sformatf("R8 table[%0d] fault", i), {63'd0, fault}, {63'd0, VT[i].flt});
         if (VT[i].wb) begin
            chk($sformatf("R3-5 table[%0d] data", i), wb_data, VT[i].exp);
            chk($sformatf("R9 table[%0d] index", i), {59'd0, wb_idx}, {59'd0, VT[i].rt});
         end
      end

      // R9: nothing written once the request is gone
      @(negedge clk);
      chk("R9 idle wb_en", {63'd0, wb_en}, 64'd0);
      chk("R9 idle fault", {63'd0, fault}, 64'd0);

      // R2: reverse-endian address adjustment, data still by virtual lane
      issue(LW, 5'd0, 5'd20, 16'h0000, 64'h100, 1'b0, 1'b1, 1'b0);
      chk("R2 word address flip", seen_addr, 64'h104);
      chk("R2 word data under reverse", wb_data, 64'hFFFF_FFFF_B5A6_9788);
      issue(LH, 5'd0, 5'd21, 16'h0000, 64'h100, 1'b0, 1'b1, 1'b0);
      chk("R2 half address flip", seen_addr, 64'h106);
      issue(LLD, 5'd0, 5'd22, 16'h0000, 64'h100, 1'b0, 1'b1, 1'b0);
      chk("R2 dword address unchanged", seen_addr, 64'h100);

      // R7: upper-immediate with a nonzero base field is not recognised
      issue(LUI, 5'd1, 5'd23, 16'h1234, 64'h0, 1'b0, 1'b0, 1'b0);
      chk("R7 bad base field no write", {63'd0, wb_en}, 64'd0);

      // R11: clear strobe
      issue(NOP, 5'd0, 5'd0, 16'h0, 64'h0, 1'b0, 1'b0, 1'b1);
      chk("R11 clear drops link", {63'd0, link_flag}, 64'd0);

      // R8: faulting load-linked leaves the flag clear
      issue(LL, 5'd0, 5'd24, 16'h0001, 64'h100, 1'b0, 1'b0, 1'b0);
      chk("R8 misaligned LL fault", {63'd0, fault}, 64'd1);
      chk("R8 misaligned LL link unchanged", {63'd0, link_flag}, 64'd0);

      // R10: successful load-linked sets the flag with its write
      issue(LL, 5'd0, 5'd25, 16'h0004, 64'h100, 1'b0, 1'b0, 1'b0);
      chk("R10 LL write", {63'd0, wb_en}, 64'd1);
      chk("R10 LL sets link", {63'd0, link_flag}, 64'd1);

      // R11: clear wins over a simultaneous set
      issue(NOP, 5'd0, 5'd0, 16'h0, 64'h0, 1'b0, 1'b0, 1'b1);
      issue(LLD, 5'd0, 5'd26, 16'h0008, 64'h100, 1'b0, 1'b0, 1'b1);
      chk("R11 write still happens", {63'd0, wb_en}, 64'd1);
      chk("R11 clear beats set", {63'd0, link_flag}, 64'd0);

      // R10: doubleword form sets it too; R8 faulting one keeps it set
      issue(LLD, 5'd0, 5'd27, 16'h0000, 64'h100, 1'b0, 1'b0, 1'b0);
      chk("R10 LLD sets link", {63'd0, link_flag}, 64'd1);
      issue(LLD, 5'd0, 5'd28, 16'h0002, 64'h100, 1'b0, 1'b0, 1'b0);
      chk("R8 fault keeps link set", {63'd0, link_flag}, 64'd1);
      chk("R8 fault no write", {63'd0, wb_en}, 64'd0);

      // R12: reset clears the link flag
      rst_n = 1'b0;
      #1;
      chk("R12 reset clears link", {63'd0, link_flag}, 64'd0);
      chk("R12 reset clears wb_en", {63'd0, wb_en}, 64'd0);

      finish_run();
   end

endmodule